// File: doc/BRIEF.md
# Typed Multi-Issue Operation Scheduler

This block is a central holding window for decoded micro-operations. Operations arrive in program order, up to four per cycle, and each takes one of 24 slots. The slot index is the operation's tag. Every operation carries a class code. There are six execution ports, and each port serves exactly one class: load, store, complex integer/multimedia, simple integer, floating point, and branch evaluation.

In every cycle, each port picks the oldest operation of its class that is still waiting and whose operand-ready bit is set. All six ports can therefore fire together. Operand readiness comes from outside as one bit per slot. Execution units report finished operations by tag on six completion lanes. The block then retires finished operations strictly in program order from the oldest slot, up to four per cycle.

A flush input discards the whole window and restarts the slot numbering.

Top module: `opSched`

## Requirements
- R1: After reset the window is empty: `insReady` is high for an offer of four, and `issValid` and `retValid` are all zero, even with every `opReady` bit set.
- R2: An insert is taken only when the number of free slots is at least `insCount` (1 to 4) and `flush` is low. When `insReady` is low, an asserted `insValid` stores nothing.
- R3: The window never holds more than 24 operations. With all 24 slots in use, `insReady` is low even for an offer of one.
- R4: Issue port p serves the class with code p (0 load, 1 store, 2 complex/multimedia, 3 simple integer, 4 floating point, 5 branch). The port shows the tag of the oldest unissued entry of that class whose `opReady` bit is set. Age is counted from the oldest slot and follows slot wrap-around.
- R5: An entry whose `opReady` bit is low is never offered for issue. An entry is offered at most once: it is marked issued at the clock edge where its port is valid.
- R6: All six ports can be valid in the same cycle, one operation per class.
- R7: Retire lane 0 is the oldest entry. Lanes fill in program order with completed entries, up to four per cycle, and stop at the first entry that is not complete. A completion reported on `cmplValid`/`cmplTag` makes the entry retirable from the next cycle on.
- R8: While `flush` is high, no issue or retire lane is valid. From the next cycle the window is empty and the next inserted operation receives tag 0.
- R9: Insert lane i receives tag (tail + i) mod 24, where tail advances by the accepted count. Tags therefore wrap from 23 back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries |
| insValid | input | 1 | Insert offer present |
| insCount | input | 3 | Number of operations offered (lanes 0..n-1) |
| insClass | input | 12 | Class code per insert lane, lane i at [3i+2:3i] |
| insPay | input | 32 | Payload per insert lane, lane i at [8i+7:8i] |
| insReady | output | 1 | Offer can be taken this cycle |
| opReady | input | 24 | Operand-ready bit per tag |
| issValid | output | 6 | Issue valid per class port |
| issTag | output | 30 | Tag per class port, port p at [5p+4:5p] |
| issPay | output | 48 | Payload per class port |
| cmplValid | input | 6 | Completion lane valid |
| cmplTag | input | 30 | Completion tag per lane |
| retValid | output | 4 | Retire lane valid, lane 0 oldest |
| retTag | output | 20 | Tag per retire lane |
| retPay | output | 32 | Payload per retire lane |

## Verification
The hardest state to reach is a window whose oldest entry sits in a high slot while younger entries of the same class occupy low slots. Only there do tag order and age order disagree. The bench gets there by filling twenty slots, completing and draining them, and then inserting two groups of loads that straddle slot 23. It then checks that the load port picks tag 20 ahead of tag 0. A second hard case is the partly full window near capacity: twenty-two entries are built up so that an offer of four is refused while an offer of two is accepted.

// File: rtl/opSchedPkg.sv
package opSchedPkg;
  localparam int DEPTH   = 24;
  localparam int INS_W   = 4;
  localparam int RET_W   = 4;
  localparam int NUM_CLS = 6;
  localparam int CLS_W   = $clog2(NUM_CLS);
  localparam int TAG_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int INSC_W  = $clog2(INS_W + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_LOAD   = 3'd0,
    CLS_STORE  = 3'd1,
    CLS_CPLX   = 3'd2,
    CLS_SIMPLE = 3'd3,
    CLS_FP     = 3'd4,
    CLS_BRANCH = 3'd5
  } opClass_e;

  // Strobes from control to the entry store
  typedef struct packed {
    logic              clearAll;
    logic              insEn;
    logic [TAG_W-1:0]  insBase;
    logic [INSC_W-1:0] insCnt;
    logic [DEPTH-1:0]  issMask;
    logic [DEPTH-1:0]  retMask;
  } schedStrobe_t;

  function automatic logic [TAG_W-1:0] wrapTag(input int idx);
    int w;
    w = idx % DEPTH;
    return TAG_W'(w);
  endfunction
endpackage

// File: rtl/opSchedData.sv
module opSchedData
  import opSchedPkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  schedStrobe_t             strobe,
  input  logic [INS_W*CLS_W-1:0]   insClass,
  input  logic [INS_W*PAY_W-1:0]   insPay,
  input  logic [NUM_CLS-1:0]       cmplValid,
  input  logic [NUM_CLS*TAG_W-1:0] cmplTag,
  output logic [DEPTH-1:0]         entVld,
  output logic [DEPTH-1:0]         entIss,
  output logic [DEPTH-1:0]         entDone,
  output logic [DEPTH*CLS_W-1:0]   entCls,
  output logic [DEPTH*PAY_W-1:0]   entPay
);

  // Per-slot status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entVld  <= '0;
      entIss  <= '0;
      entDone <= '0;
    end else if (strobe.clearAll) begin
      entVld  <= '0;
      entIss  <= '0;
      entDone <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (strobe.retMask[s]) begin
          entVld[s]  <= 1'b0;
          entIss[s]  <= 1'b0;
          entDone[s] <= 1'b0;
        end else if (strobe.issMask[s]) begin
          entIss[s] <= 1'b1;
        end
      end
      for (int p = 0; p < NUM_CLS; p++) begin
        if (cmplValid[p] && int'(cmplTag[p*TAG_W +: TAG_W]) < DEPTH &&
            entVld[cmplTag[p*TAG_W +: TAG_W]] && !entDone[cmplTag[p*TAG_W +: TAG_W]])
          entDone[cmplTag[p*TAG_W +: TAG_W]] <= 1'b1;
      end
      if (strobe.insEn) begin
        for (int l = 0; l < INS_W; l++) begin
          if (l < int'(strobe.insCnt)) begin
            entVld[wrapTag(int'(strobe.insBase) + l)]  <= 1'b1;
            entIss[wrapTag(int'(strobe.insBase) + l)]  <= 1'b0;
            entDone[wrapTag(int'(strobe.insBase) + l)] <= 1'b0;
          end
        end
      end
    end
  end

  // Class and payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.insEn && !strobe.clearAll) begin
      for (int l = 0; l < INS_W; l++) begin
        if (l < int'(strobe.insCnt)) begin
          entCls[int'(wrapTag(int'(strobe.insBase) + l))*CLS_W +: CLS_W] <= insClass[l*CLS_W +: CLS_W];
          entPay[int'(wrapTag(int'(strobe.insBase) + l))*PAY_W +: PAY_W] <= insPay[l*PAY_W +: PAY_W];
        end
      end
    end
  end

endmodule

// File: rtl/opSchedCtrl.sv
module opSchedCtrl
  import opSchedPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     insValid,
  input  logic [INSC_W-1:0]        insCount,
  input  logic [DEPTH-1:0]         opReady,
  input  logic [DEPTH-1:0]         entVld,
  input  logic [DEPTH-1:0]         entIss,
  input  logic [DEPTH-1:0]         entDone,
  input  logic [DEPTH*CLS_W-1:0]   entCls,
  output logic                     insReady,
  output logic [NUM_CLS-1:0]       issValid,
  output logic [NUM_CLS*TAG_W-1:0] issTag,
  output logic [RET_W-1:0]         retValid,
  output logic [RET_W*TAG_W-1:0]   retTag,
  output schedStrobe_t             strobe
);

  logic [TAG_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic             insAcc;
  logic [DEPTH-1:0] issMask, retMask;
  logic [TAG_W-1:0] iSlot, rSlot;
  logic             blocked;
  int               retN;

  always_comb begin
    insReady = !flush && (int'(insCount) <= INS_W) &&
               (int'(countQ) + int'(insCount) <= DEPTH);
    insAcc   = insValid && insReady;
  end

  // Oldest-first pick per class port
  always_comb begin
    issValid = '0;
    issTag   = '0;
    issMask  = '0;
    iSlot    = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      for (int k = 0; k < DEPTH; k++) begin
        iSlot = wrapTag(int'(headQ) + k);
        if (!flush && !issValid[c] && entVld[iSlot] && !entIss[iSlot] && opReady[iSlot] &&
            entCls[int'(iSlot)*CLS_W +: CLS_W] == CLS_W'(c)) begin
          issValid[c]              = 1'b1;
          issTag[c*TAG_W +: TAG_W] = iSlot;
          issMask[iSlot]           = 1'b1;
        end
      end
    end
  end

  // In-order retire window from head
  always_comb begin
    retValid = '0;
    retTag   = '0;
    retMask  = '0;
    retN     = 0;
    rSlot    = '0;
    blocked  = flush;
    for (int r = 0; r < RET_W; r++) begin
      rSlot = wrapTag(int'(headQ) + r);
      if (!blocked && r < int'(countQ) && entDone[rSlot]) begin
        retValid[r]              = 1'b1;
        retTag[r*TAG_W +: TAG_W] = rSlot;
        retMask[rSlot]           = 1'b1;
        retN                     = retN + 1;
      end else begin
        blocked = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clearAll = flush;
    strobe.insEn    = insAcc;
    strobe.insBase  = tailQ;
    strobe.insCnt   = insCount;
    strobe.issMask  = issMask;
    strobe.retMask  = retMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else if (flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ <= wrapTag(int'(headQ) + retN);
      if (insAcc) tailQ <= wrapTag(int'(tailQ) + int'(insCount));
      countQ <= CNT_W'(int'(countQ) + (insAcc ? int'(insCount) : 0) - retN);
    end
  end

endmodule

// File: rtl/opSched.sv
module opSched
  import opSchedPkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     insValid,
  input  logic [INSC_W-1:0]        insCount,
  input  logic [INS_W*CLS_W-1:0]   insClass,
  input  logic [INS_W*PAY_W-1:0]   insPay,
  output logic                     insReady,
  input  logic [DEPTH-1:0]         opReady,
  output logic [NUM_CLS-1:0]       issValid,
  output logic [NUM_CLS*TAG_W-1:0] issTag,
  output logic [NUM_CLS*PAY_W-1:0] issPay,
  input  logic [NUM_CLS-1:0]       cmplValid,
  input  logic [NUM_CLS*TAG_W-1:0] cmplTag,
  output logic [RET_W-1:0]         retValid,
  output logic [RET_W*TAG_W-1:0]   retTag,
  output logic [RET_W*PAY_W-1:0]   retPay
);

  schedStrobe_t             strobe;
  logic [DEPTH-1:0]         entVld, entIss, entDone;
  logic [DEPTH*CLS_W-1:0]   entCls;
  logic [DEPTH*PAY_W-1:0]   entPay;

  opSchedCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .insCount(insCount),
    .opReady(opReady), .entVld(entVld), .entIss(entIss), .entDone(entDone), .entCls(entCls),
    .insReady(insReady), .issValid(issValid), .issTag(issTag), .retValid(retValid),
    .retTag(retTag), .strobe(strobe)
  );

  opSchedData #(.PAY_W(PAY_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insClass(insClass), .insPay(insPay),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .entVld(entVld), .entIss(entIss),
    .entDone(entDone), .entCls(entCls), .entPay(entPay)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_issPay
    assign issPay[c*PAY_W +: PAY_W] = entPay[int'(issTag[c*TAG_W +: TAG_W])*PAY_W +: PAY_W];
  end

  for (genvar r = 0; r < RET_W; r++) begin : g_retPay
    assign retPay[r*PAY_W +: PAY_W] = entPay[int'(retTag[r*TAG_W +: TAG_W])*PAY_W +: PAY_W];
  end

endmodule

// File: rtl/opSchedChk.sv
module opSchedChk
  import opSchedPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     flush,
  input logic                     insValid,
  input logic                     insReady,
  input logic [INSC_W-1:0]        insCount,
  input logic [NUM_CLS-1:0]       issValid,
  input logic [NUM_CLS*TAG_W-1:0] issTag,
  input logic [RET_W-1:0]         retValid,
  input logic [DEPTH-1:0]         entVld,
  input logic [DEPTH*CLS_W-1:0]   entCls
);

  assert_refused_no_growth_R2: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insReady && !flush) |=>
      $countones(entVld) == $past($countones(entVld)) - $past($countones(retValid)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insReady) |-> ($countones(entVld) + int'(insCount) <= DEPTH));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (issValid == '0 && retValid == '0));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (entVld == '0));

  for (genvar r = 1; r < RET_W; r++) begin : g_retOrder
    assert_retire_contig_R7: assert property (@(posedge clk) disable iff (!rstN)
      retValid[r] |-> retValid[r-1]);
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_port
    assert_port_class_R4: assert property (@(posedge clk) disable iff (!rstN)
      issValid[c] |-> (entVld[issTag[c*TAG_W +: TAG_W]] &&
        entCls[int'(issTag[c*TAG_W +: TAG_W])*CLS_W +: CLS_W] == CLS_W'(c)));
    assert_issue_once_R5: assert property (@(posedge clk) disable iff (!rstN)
      issValid[c] |=> !(issValid[c] && issTag[c*TAG_W +: TAG_W] == $past(issTag[c*TAG_W +: TAG_W])));
  end

endmodule

bind opSched opSchedChk chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .insReady(insReady),
  .insCount(insCount), .issValid(issValid), .issTag(issTag), .retValid(retValid),
  .entVld(entVld), .entCls(entCls)
);

// File: tb/opSched_tb_top.sv
`timescale 1ns/1ps
module opSched_tb_top;
  import opSchedPkg::*;
  localparam int PAY_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic insValid = 1'b0;
  logic [INSC_W-1:0] insCount = '0;
  logic [INS_W*CLS_W-1:0] insClass = '0;
  logic [INS_W*PAY_W-1:0] insPay = '0;
  logic insReady;
  logic [DEPTH-1:0] opReady = '0;
  logic [NUM_CLS-1:0] issValid;
  logic [NUM_CLS*TAG_W-1:0] issTag;
  logic [NUM_CLS*PAY_W-1:0] issPay;
  logic [NUM_CLS-1:0] cmplValid = '0;
  logic [NUM_CLS*TAG_W-1:0] cmplTag = '0;
  logic [RET_W-1:0] retValid;
  logic [RET_W*TAG_W-1:0] retTag;
  logic [RET_W*PAY_W-1:0] retPay;

  always #2.5 clk = ~clk;

  opSched #(.PAY_W(PAY_W)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .insValid(insValid), .insCount(insCount),
    .insClass(insClass), .insPay(insPay), .insReady(insReady), .opReady(opReady),
    .issValid(issValid), .issTag(issTag), .issPay(issPay), .cmplValid(cmplValid),
    .cmplTag(cmplTag), .retValid(retValid), .retTag(retTag), .retPay(retPay)
  );

  int checks = 0;
  int errors = 0;
  bit acc;

  // {classes lane3..lane0, ready tags3..0, expected port mask, expected tags port5..port0}
  localparam logic [51:0] VEC [0:5] = '{
    {3'd2, 3'd1, 3'd0, 3'd0, 4'b1111, 6'b000111, 5'd0, 5'd0, 5'd0, 5'd3, 5'd2, 5'd0},
    {3'd2, 3'd1, 3'd0, 3'd0, 4'b1110, 6'b000111, 5'd0, 5'd0, 5'd0, 5'd3, 5'd2, 5'd1},
    {3'd3, 3'd5, 3'd4, 3'd3, 4'b1111, 6'b111000, 5'd2, 5'd1, 5'd0, 5'd0, 5'd0, 5'd0},
    {3'd3, 3'd3, 3'd3, 3'd3, 4'b1100, 6'b001000, 5'd0, 5'd0, 5'd2, 5'd0, 5'd0, 5'd0},
    {3'd0, 3'd1, 3'd4, 3'd5, 4'b0000, 6'b000000, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0},
    {3'd5, 3'd0, 3'd5, 3'd5, 4'b1010, 6'b100000, 5'd1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}
  };

  localparam logic [11:0] ALL_SIMPLE = {3'd3, 3'd3, 3'd3, 3'd3};
  localparam logic [11:0] ALL_LOAD   = 12'd0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkIssue(input string req, input logic [5:0] mask, input logic [29:0] tags);
    check({req, " port mask"}, int'(issValid), int'(mask));
    for (int p = 0; p < NUM_CLS; p++)
      if (mask[p]) check({req, " port tag"}, int'(issTag[p*TAG_W +: TAG_W]), int'(tags[p*5 +: 5]));
  endtask

  task automatic doInsert(input int n, input logic [11:0] cls, input int payBase, output bit ok);
    @(negedge clk);
    insValid = 1'b1;
    insCount = INSC_W'(n);
    insClass = cls;
    for (int l = 0; l < INS_W; l++) insPay[l*PAY_W +: PAY_W] = PAY_W'(payBase + l);
    #1 ok = insReady;
    @(negedge clk);
    insValid = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    opReady = '0;
    cmplValid = '0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic doCmpl(input logic [5:0] v, input logic [29:0] t);
    @(negedge clk);
    cmplValid = v;
    cmplTag = t;
    @(negedge clk);
    cmplValid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    insCount = 3'd4;
    opReady = '1;
    #1;
    check("R1 insReady", int'(insReady), 1);
    check("R1 issValid", int'(issValid), 0);
    check("R1 retValid", int'(retValid), 0);
    opReady = '0;

    // Table walk: R4 class pick and R5 readiness gating
    for (int i = 0; i < 6; i++) begin
      doFlush();
      doInsert(4, VEC[i][51:40], 0, acc);
      opReady = {20'd0, VEC[i][39:36]};
      #1 checkIssue("R4 R5 table", VEC[i][35:30], VEC[i][29:0]);
    end

    // R6 all six ports together, then R5 issued once
    doFlush();
    doInsert(4, {3'd3, 3'd2, 3'd1, 3'd0}, 0, acc);
    doInsert(2, {6'd0, 3'd5, 3'd4}, 0, acc);
    opReady = '1;
    #1 checkIssue("R6 six ports", 6'h3f, {5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0});
    @(negedge clk);
    #1 check("R5 issued only once", int'(issValid), 0);
    opReady = '0;

    // R4 oldest-first within one class
    doFlush();
    doInsert(3, ALL_SIMPLE, 0, acc);
    opReady = '1;
    for (int k = 0; k < 3; k++) begin
      #1 check("R4 simple valid", int'(issValid[3]), 1);
      check("R4 simple oldest tag", int'(issTag[3*TAG_W +: TAG_W]), k);
      @(negedge clk);
    end
    #1 check("R5 no reissue", int'(issValid), 0);
    opReady = '0;

    // R7 in-order retire, stop at incomplete head
    doFlush();
    doInsert(4, ALL_SIMPLE, 8'hA0, acc);
    doInsert(2, ALL_SIMPLE, 8'hA4, acc);
    doCmpl(6'b000011, {20'd0, 5'd2, 5'd1});
    #1 check("R7 head incomplete", int'(retValid), 0);
    doCmpl(6'b000001, {25'd0, 5'd0});
    #1 check("R7 retire lanes", int'(retValid), 7);
    for (int r = 0; r < 3; r++) check("R7 retire tag", int'(retTag[r*TAG_W +: TAG_W]), r);
    check("R7 retire payload", int'(retPay[2*PAY_W +: PAY_W]), 8'hA2);
    @(negedge clk);
    #1 check("R7 rest incomplete", int'(retValid), 0);
    doCmpl(6'b000111, {15'd0, 5'd5, 5'd4, 5'd3});
    #1 check("R7 second group", int'(retValid), 7);
    check("R7 second tag", int'(retTag[0 +: TAG_W]), 3);

    // R7 limit of four per cycle
    doFlush();
    doInsert(4, ALL_SIMPLE, 0, acc);
    doInsert(2, ALL_SIMPLE, 0, acc);
    doCmpl(6'h3f, {5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0});
    #1 check("R7 four lanes", int'(retValid), 15);
    check("R7 lane3 tag", int'(retTag[3*TAG_W +: TAG_W]), 3);
    @(negedge clk);
    #1 check("R7 remaining two", int'(retValid), 3);
    check("R7 lane0 tag after", int'(retTag[0 +: TAG_W]), 4);
    @(negedge clk);
    #1 check("R7 drained", int'(retValid), 0);

    // R2 / R3 capacity
    doFlush();
    for (int g = 0; g < 5; g++) doInsert(4, ALL_SIMPLE, 0, acc);
    doInsert(2, ALL_SIMPLE, 0, acc);
    @(negedge clk);
    insValid = 1'b1;
    insCount = 3'd4;
    insClass = ALL_LOAD;
    #1 check("R2 refuse four with two free", int'(insReady), 0);
    @(negedge clk);
    insValid = 1'b0;
    opReady = '1;
    #1 check("R2 refused loads not stored", int'(issValid[0]), 0);
    check("R2 simple still there", int'(issTag[3*TAG_W +: TAG_W]), 0);
    opReady = '0;
    doInsert(2, ALL_LOAD, 0, acc);
    check("R2 accept two with two free", int'(acc), 1);
    opReady = '1;
    #1 check("R9 load tag after fill", int'(issTag[0 +: TAG_W]), 22);
    insCount = 3'd1;
    #1 check("R3 full refuses one", int'(insReady), 0);
    opReady = '0;

    // R9 tag wrap and R4 age across wrap
    doFlush();
    for (int g = 0; g < 5; g++) doInsert(4, ALL_SIMPLE, 0, acc);
    doCmpl(6'h3f, {5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0});
    doCmpl(6'h3f, {5'd11, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6});
    doCmpl(6'h3f, {5'd17, 5'd16, 5'd15, 5'd14, 5'd13, 5'd12});
    doCmpl(6'b000011, {20'd0, 5'd19, 5'd18});
    repeat (6) @(negedge clk);
    #1 check("R7 all drained", int'(retValid), 0);
    doInsert(4, ALL_LOAD, 0, acc);
    check("R2 accept after drain", int'(acc), 1);
    doInsert(4, ALL_LOAD, 0, acc);
    opReady = '1;
    #1 check("R4 oldest across wrap", int'(issTag[0 +: TAG_W]), 20);
    opReady = 24'h1;
    #1 check("R9 wrapped tag zero", int'(issValid[0]), 1);
    check("R9 wrapped tag value", int'(issTag[0 +: TAG_W]), 0);
    opReady = '0;

    // R8 flush
    @(negedge clk);
    flush = 1'b1;
    opReady = '1;
    #1 check("R8 quiet during flush", int'(issValid), 0);
    @(negedge clk);
    flush = 1'b0;
    insCount = 3'd4;
    #1 check("R8 empty after flush", int'(issValid), 0);
    check("R8 no retire after flush", int'(retValid), 0);
    check("R8 room after flush", int'(insReady), 1);
    opReady = '0;
    doInsert(1, {9'd0, 3'd5}, 0, acc);
    opReady = '1;
    #1 check("R8 branch valid", int'(issValid[5]), 1);
    check("R8 tag restarts", int'(issTag[5*TAG_W +: TAG_W]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule